// File: doc/BRIEF.md
# Tunable Laser Bring-Up and Recovery Sequencer

This block is the control sequencer for a tunable transmit laser or local oscillator. It reads status flags from the analog control loops, the coherent DSP and the calibration engine. From those flags it turns on, one stage at a time, the temperature loop, the wavelength locker, the power and bias loops and a calibration request. It asserts a ready flag only once every stage has shown stable operation. The analog loops, the DSP and the calibration routines sit outside the block. The block models only ordering, per-stage time limits and the retry policy.

Each stage waits for its own exit condition, and a programmable cycle limit bounds that wait. The lock stage looks at a three-way margin class rather than a single locked bit. When lock is lost after it was first acquired, the sequencer switches the loops off one at a time in the reverse of the order it turned them on. It then restarts from the thermal stage, and this time it asks only for a reduced calibration. A failed stage or a lost lock costs one automatic attempt. When the attempts run out, the sequencer parks in a latched fault state that only an explicit clear releases.

Top module: `laser_seq_top`

## Requirements
- R1: After reset all four loop enables, calReq, calFull and ready are 0, stateCode is 0 (idle) and faultCode is 0.
- R2: stateCode values are idle 0, thermal 1, lock 2, power 3, DSP 4, calibration 5, ready 6, unwind 7, fault 8. A startReq pulse in idle moves the sequencer to thermal with tecEn set. The stages then advance strictly thermal, lock, power, DSP, calibration, ready. lockerEn is set on leaving thermal, apcEn and biasEn are set together on leaving lock, and ready is 1 only in the ready state.
- R3: The thermal stage advances only when tecSettled is 1 and tecOscillating is 0 in the same cycle.
- R4: lockClass encodes 2'b10 locked, 2'b01 near-edge, and 2'b00 or 2'b11 unlocked. The lock stage advances only on the locked code and never while near-edge.
- R5: The DSP stage advances only when phaseOk, cfoStable and slipFree are all 1 in the same cycle.
- R6: In calibration, calDone while calReq is 1, with calTimeout and calSaturated both 0, leads to ready. calTimeout or calSaturated while calReq is 1 is a failure with faultCode 5 and never leads to ready.
- R7: A calibration during first bring-up is full (calFull 1). Its calReq is held at 0 while lockClass is not the locked code, and calDone is ignored while calReq is 0. After any recovery the calibration is reduced (calFull 0) and is requested whatever the margin class.
- R8: A stage whose exit condition stays false occupies exactly stageTimeout+1 cycles and then fails. The faultCode is thermal 1, lock 2, power 3, DSP 4, calibration 5.
- R9: An unlocked lockClass in the power, DSP, calibration or ready states is a lock loss with faultCode 6. The unwind state clears biasEn, then apcEn, then lockerEn on three successive cycles while tecEn stays 1, and the sequencer then re-enters thermal.
- R10: Each failure or lock loss uses one of MAX_RETRY automatic attempts. The failure after they are used up unwinds into the fault state with all enables 0 (tecEn clears with lockerEn) and keeps faultCode. The fault state holds until faultClear, which returns to idle with faultCode 0.
- R11: Reaching ready restores the full retry budget and clears faultCode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin bring-up from idle |
| faultClear | input | 1 | Release the latched fault state |
| stageTimeout | input | TIMER_W | Per-stage cycle limit |
| tecSettled | input | 1 | Temperature loop has settled |
| tecOscillating | input | 1 | Temperature loop is oscillating |
| lockClass | input | 2 | Wavelength lock margin class |
| apcSettled | input | 1 | Power control has settled |
| phaseOk | input | 1 | DSP phase error is stable |
| cfoStable | input | 1 | DSP frequency-offset estimate is stable |
| slipFree | input | 1 | No cycle slips seen |
| calDone | input | 1 | Calibration has finished |
| calTimeout | input | 1 | Calibration ended by timing out |
| calSaturated | input | 1 | Calibration ended with a saturated correction |
| tecEn | output | 1 | Temperature loop enable |
| lockerEn | output | 1 | Wavelength locker enable |
| apcEn | output | 1 | Power control enable |
| biasEn | output | 1 | Modulator bias loop enable |
| calReq | output | 1 | Calibration request |
| calFull | output | 1 | 1 for full calibration, 0 for reduced |
| ready | output | 1 | Laser is ready for traffic |
| stateCode | output | 4 | Current sequencer state |
| faultCode | output | 3 | Cause of the most recent failure |

## Verification
The assertions assume that status flags are synchronous to clk, that lockClass holds one of its four codes, and that the calibration result flags are meaningful only while calReq is 1. The stimulus changes every input only away from the rising edge. It holds each input pattern for whole cycles and raises calibration results only while the block is in its calibration state. Thermal, lock and DSP flag combinations are swept exhaustively, one cycle each, with a stage limit long enough that the sweep never trips a timeout. Separate runs then shorten the limit to count stage residency cycle by cycle.

// File: rtl/laser_seq_pkg.sv
package laser_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_THERM  = 4'd1,
    ST_LOCK   = 4'd2,
    ST_POWER  = 4'd3,
    ST_DSP    = 4'd4,
    ST_CAL    = 4'd5,
    ST_READY  = 4'd6,
    ST_UNWIND = 4'd7,
    ST_FAULT  = 4'd8
  } seqState_e;

  localparam logic [1:0] LK_UNLOCKED = 2'b00;
  localparam logic [1:0] LK_NEAR     = 2'b01;
  localparam logic [1:0] LK_LOCKED   = 2'b10;

  localparam logic [2:0] FC_NONE  = 3'd0;
  localparam logic [2:0] FC_THERM = 3'd1;
  localparam logic [2:0] FC_LOCK  = 3'd2;
  localparam logic [2:0] FC_POWER = 3'd3;
  localparam logic [2:0] FC_DSP   = 3'd4;
  localparam logic [2:0] FC_CAL   = 3'd5;
  localparam logic [2:0] FC_LOSS  = 3'd6;

  // loop index: 0 temperature, 1 locker, 2 power, 3 bias
  localparam int N_LOOPS = 4;

  typedef struct packed {
    logic                timerRestart;
    logic                timerRun;
    logic [N_LOOPS-1:0]  loopOn;
    logic [N_LOOPS-1:0]  loopOff;
    logic                retryInc;
    logic                retryClr;
    logic                recoverSet;
    logic                recoverClr;
    logic                faultLoad;
    logic                faultClr;
    logic [2:0]          faultVal;
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import laser_seq_pkg::*;
#(
  parameter int TIMER_W   = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [TIMER_W-1:0] stageTimeout,
  output logic [N_LOOPS-1:0] loopEn,
  output logic               timerExpired,
  output logic               retryAtMax,
  output logic               recovering,
  output logic [2:0]         faultCode
);

  localparam int RETRY_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  logic [TIMER_W-1:0] stageTimer;
  logic [RETRY_W-1:0] retryCnt;

  genvar gi;
  generate
    for (gi = 0; gi < N_LOOPS; gi++) begin : gLoop
      always_ff @(posedge clk) begin
        if (!rstN)                  loopEn[gi] <= 1'b0;
        else if (strobe.loopOff[gi]) loopEn[gi] <= 1'b0;
        else if (strobe.loopOn[gi])  loopEn[gi] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                                          stageTimer <= '0;
    else if (strobe.timerRestart)                       stageTimer <= '0;
    else if (strobe.timerRun && stageTimer < stageTimeout) stageTimer <= stageTimer + TIMER_W'(1);
  end

  assign timerExpired = strobe.timerRun && (stageTimer >= stageTimeout);

  always_ff @(posedge clk) begin
    if (!rstN)                retryCnt <= '0;
    else if (strobe.retryClr) retryCnt <= '0;
    else if (strobe.retryInc) retryCnt <= retryCnt + RETRY_W'(1);
  end

  assign retryAtMax = (retryCnt == RETRY_W'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (!rstN)                  recovering <= 1'b0;
    else if (strobe.recoverClr) recovering <= 1'b0;
    else if (strobe.recoverSet) recovering <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 faultCode <= FC_NONE;
    else if (strobe.faultLoad) faultCode <= strobe.faultVal;
    else if (strobe.faultClr)  faultCode <= FC_NONE;
  end

  // R2
  lockerNeedsTec_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopEn[1]) |-> loopEn[0]);
  // R2
  powerNeedsLocker_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopEn[2]) |-> loopEn[1]);
  // R9
  biasBeforePower_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loopEn[2]) |-> !loopEn[3]);
  // R9
  powerBeforeLocker_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loopEn[1]) |-> !loopEn[2]);
  // R10
  retryBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RETRY_W'(MAX_RETRY));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import laser_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       faultClear,
  input  logic       tecSettled,
  input  logic       tecOscillating,
  input  logic [1:0] lockClass,
  input  logic       apcSettled,
  input  logic       phaseOk,
  input  logic       cfoStable,
  input  logic       slipFree,
  input  logic       calDone,
  input  logic       calTimeout,
  input  logic       calSaturated,
  input  logic       timerExpired,
  input  logic       retryAtMax,
  input  logic       recovering,
  output seqStrobe_t strobe,
  output seqState_e  state,
  output logic       calReq,
  output logic       calFull,
  output logic       ready
);

  seqState_e  nextState;
  logic [1:0] unwindStep, nextStep;
  logic       unwindToFault, nextToFault;
  logic       failNow;
  logic [2:0] failCode;
  logic       lockLost, lockGood;

  assign lockLost = (lockClass == LK_UNLOCKED) || (lockClass == 2'b11);
  assign lockGood = (lockClass == LK_LOCKED);

  assign calReq  = (state == ST_CAL) && (recovering || lockGood);
  assign calFull = (state == ST_CAL) && !recovering;
  assign ready   = (state == ST_READY);

  always_comb begin
    strobe      = '0;
    nextState   = state;
    nextStep    = unwindStep;
    nextToFault = unwindToFault;
    failNow     = 1'b0;
    failCode    = FC_NONE;

    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState           = ST_THERM;
          strobe.loopOn[0]    = 1'b1;
          strobe.timerRestart = 1'b1;
          strobe.recoverClr   = 1'b1;
        end
      end
      ST_THERM: begin
        strobe.timerRun = 1'b1;
        if (tecSettled && !tecOscillating) begin
          nextState           = ST_LOCK;
          strobe.loopOn[1]    = 1'b1;
          strobe.timerRestart = 1'b1;
        end else if (timerExpired) begin
          failNow  = 1'b1;
          failCode = FC_THERM;
        end
      end
      ST_LOCK: begin
        strobe.timerRun = 1'b1;
        if (lockGood) begin
          nextState           = ST_POWER;
          strobe.loopOn[2]    = 1'b1;
          strobe.loopOn[3]    = 1'b1;
          strobe.timerRestart = 1'b1;
        end else if (timerExpired) begin
          failNow  = 1'b1;
          failCode = FC_LOCK;
        end
      end
      ST_POWER: begin
        strobe.timerRun = 1'b1;
        if (lockLost) begin
          failNow  = 1'b1;
          failCode = FC_LOSS;
        end else if (apcSettled) begin
          nextState           = ST_DSP;
          strobe.timerRestart = 1'b1;
        end else if (timerExpired) begin
          failNow  = 1'b1;
          failCode = FC_POWER;
        end
      end
      ST_DSP: begin
        strobe.timerRun = 1'b1;
        if (lockLost) begin
          failNow  = 1'b1;
          failCode = FC_LOSS;
        end else if (phaseOk && cfoStable && slipFree) begin
          nextState           = ST_CAL;
          strobe.timerRestart = 1'b1;
        end else if (timerExpired) begin
          failNow  = 1'b1;
          failCode = FC_DSP;
        end
      end
      ST_CAL: begin
        strobe.timerRun = 1'b1;
        if (lockLost) begin
          failNow  = 1'b1;
          failCode = FC_LOSS;
        end else if (calReq && (calTimeout || calSaturated)) begin
          failNow  = 1'b1;
          failCode = FC_CAL;
        end else if (calReq && calDone) begin
          nextState       = ST_READY;
          strobe.retryClr = 1'b1;
          strobe.faultClr = 1'b1;
        end else if (timerExpired) begin
          failNow  = 1'b1;
          failCode = FC_CAL;
        end
      end
      ST_READY: begin
        if (lockLost) begin
          failNow  = 1'b1;
          failCode = FC_LOSS;
        end
      end
      ST_UNWIND: begin
        unique case (unwindStep)
          2'd0: begin
            strobe.loopOff[3] = 1'b1;
            nextStep          = 2'd1;
          end
          2'd1: begin
            strobe.loopOff[2] = 1'b1;
            nextStep          = 2'd2;
          end
          default: begin
            strobe.loopOff[1] = 1'b1;
            nextStep          = 2'd0;
            if (unwindToFault) begin
              strobe.loopOff[0] = 1'b1;
              nextState         = ST_FAULT;
            end else begin
              nextState           = ST_THERM;
              strobe.timerRestart = 1'b1;
            end
          end
        endcase
      end
      ST_FAULT: begin
        if (faultClear) begin
          nextState         = ST_IDLE;
          strobe.retryClr   = 1'b1;
          strobe.faultClr   = 1'b1;
          strobe.recoverClr = 1'b1;
          nextToFault       = 1'b0;
        end
      end
      default: nextState = ST_IDLE;
    endcase

    if (failNow) begin
      nextState         = ST_UNWIND;
      nextStep          = 2'd0;
      strobe.faultLoad  = 1'b1;
      strobe.faultVal   = failCode;
      strobe.recoverSet = 1'b1;
      if (retryAtMax) begin
        nextToFault = 1'b1;
      end else begin
        nextToFault     = 1'b0;
        strobe.retryInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      unwindStep    <= 2'd0;
      unwindToFault <= 1'b0;
    end else begin
      state         <= nextState;
      unwindStep    <= nextStep;
      unwindToFault <= nextToFault;
    end
  end

  // R4
  nearEdgeHolds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && lockClass == LK_NEAR) |=> (state == ST_LOCK || state == ST_UNWIND));
  // R6
  calFailNoReady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAL && (calTimeout || calSaturated)) |=> state != ST_READY);
  // R10
  faultLatched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && !faultClear) |=> state == ST_FAULT);
  // R9
  lossUnwinds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && lockLost) |=> state == ST_UNWIND);

endmodule

// File: rtl/laser_seq_top.sv
module laser_seq_top
  import laser_seq_pkg::*;
#(
  parameter int TIMER_W   = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               faultClear,
  input  logic [TIMER_W-1:0] stageTimeout,
  input  logic               tecSettled,
  input  logic               tecOscillating,
  input  logic [1:0]         lockClass,
  input  logic               apcSettled,
  input  logic               phaseOk,
  input  logic               cfoStable,
  input  logic               slipFree,
  input  logic               calDone,
  input  logic               calTimeout,
  input  logic               calSaturated,
  output logic               tecEn,
  output logic               lockerEn,
  output logic               apcEn,
  output logic               biasEn,
  output logic               calReq,
  output logic               calFull,
  output logic               ready,
  output logic [3:0]         stateCode,
  output logic [2:0]         faultCode
);

  seqStrobe_t         strobe;
  seqState_e          state;
  logic [N_LOOPS-1:0] loopEn;
  logic               timerExpired, retryAtMax, recovering;

  seq_control uCtrl (
    .clk, .rstN, .startReq, .faultClear, .tecSettled, .tecOscillating,
    .lockClass, .apcSettled, .phaseOk, .cfoStable, .slipFree,
    .calDone, .calTimeout, .calSaturated,
    .timerExpired, .retryAtMax, .recovering,
    .strobe, .state, .calReq, .calFull, .ready
  );

  seq_datapath #(.TIMER_W(TIMER_W), .MAX_RETRY(MAX_RETRY)) uPath (
    .clk, .rstN, .strobe, .stageTimeout,
    .loopEn, .timerExpired, .retryAtMax, .recovering, .faultCode
  );

  assign tecEn     = loopEn[0];
  assign lockerEn  = loopEn[1];
  assign apcEn     = loopEn[2];
  assign biasEn    = loopEn[3];
  assign stateCode = state;

  // R2
  readyAllLoops_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (tecEn && lockerEn && apcEn && biasEn));

endmodule

// File: tb/tb_laser_seq_top.sv
`timescale 1ns/1ps
module tb_laser_seq_top;

  localparam int TW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, faultClear = 0;
  logic [TW-1:0] stageTimeout = 8'd40;
  logic tecSettled = 0, tecOscillating = 0;
  logic [1:0] lockClass = 2'b00;
  logic apcSettled = 0, phaseOk = 0, cfoStable = 0, slipFree = 0;
  logic calDone = 0, calTimeout = 0, calSaturated = 0;
  logic tecEn, lockerEn, apcEn, biasEn, calReq, calFull, ready;
  logic [3:0] stateCode;
  logic [2:0] faultCode;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  laser_seq_top #(.TIMER_W(TW), .MAX_RETRY(2)) dut (
    .clk, .rstN, .startReq, .faultClear, .stageTimeout,
    .tecSettled, .tecOscillating, .lockClass, .apcSettled,
    .phaseOk, .cfoStable, .slipFree, .calDone, .calTimeout, .calSaturated,
    .tecEn, .lockerEn, .apcEn, .biasEn, .calReq, .calFull, .ready,
    .stateCode, .faultCode
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input int exp);
    chk(stateCode == exp, req, stateCode, exp);
  endtask

  task automatic countIn(input int s, output int n);
    n = 0;
    while (stateCode == s && n < 200) begin
      n++;
      tick();
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    ticks(3);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk({tecEn, lockerEn, apcEn, biasEn, calReq, calFull, ready} == 7'd0, "R1 outputs",
        {tecEn, lockerEn, apcEn, biasEn, calReq, calFull, ready}, 0);
    chkState("R1 state", 0);
    chk(faultCode == 0, "R1 fault", faultCode, 0);

    // R2 start
    startReq = 1; tick(); startReq = 0;
    chkState("R2 thermal entry", 1);
    chk(tecEn == 1 && lockerEn == 0, "R2 tec only", {tecEn, lockerEn}, 2);

    // R3 sweep of thermal flags
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      {tecSettled, tecOscillating} = c[1:0];
      tick();
      chkState("R3 thermal hold", 1);
    end
    tecSettled = 1; tecOscillating = 0; tick();
    chkState("R3 thermal advance", 2);
    chk(lockerEn == 1 && apcEn == 0, "R2 locker on", {lockerEn, apcEn}, 2);

    // R4 sweep of lock classes
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      lockClass = c[1:0];
      tick();
      chkState("R4 lock hold", 2);
      chk(apcEn == 0, "R4 no power", apcEn, 0);
    end
    lockClass = 2'b10; tick();
    chkState("R4 lock advance", 3);
    chk(apcEn == 1 && biasEn == 1, "R2 power and bias on", {apcEn, biasEn}, 3);

    apcSettled = 0; tick();
    chkState("R2 power hold", 3);
    apcSettled = 1; tick();
    chkState("R2 power advance", 4);

    // R5 sweep of DSP flags
    for (int c = 0; c < 7; c++) begin
      {phaseOk, cfoStable, slipFree} = c[2:0];
      tick();
      chkState("R5 dsp hold", 4);
    end
    {phaseOk, cfoStable, slipFree} = 3'b111; tick();
    chkState("R5 dsp advance", 5);

    // R7 full calibration gated on margin
    chk(calFull == 1, "R7 full cal", calFull, 1);
    lockClass = 2'b01; calDone = 1; #1;
    chk(calReq == 0, "R7 withheld near-edge", calReq, 0);
    tick();
    chkState("R7 done ignored", 5);
    lockClass = 2'b10; #1;
    chk(calReq == 1, "R7 request locked", calReq, 1);
    tick(); calDone = 0;
    chkState("R6 ready", 6);
    chk(ready == 1, "R2 ready flag", ready, 1);

    // R9 lock loss unwind
    lockClass = 2'b00; tick();
    chkState("R9 unwind", 7);
    chk(ready == 0 && biasEn == 1, "R9 step0", {ready, biasEn}, 1);
    tick();
    chk(biasEn == 0 && apcEn == 1, "R9 bias first", {biasEn, apcEn}, 1);
    tick();
    chk(apcEn == 0 && lockerEn == 1, "R9 power second", {apcEn, lockerEn}, 1);
    tick();
    chk(lockerEn == 0 && tecEn == 1, "R9 locker third", {lockerEn, tecEn}, 1);
    chkState("R9 thermal again", 1);
    chk(faultCode == 6, "R9 code", faultCode, 6);

    // R7 reduced calibration on recovery
    lockClass = 2'b10; ticks(4);
    chkState("R7 recovery cal", 5);
    chk(calFull == 0, "R7 reduced", calFull, 0);
    lockClass = 2'b01; #1;
    chk(calReq == 1, "R7 reduced near-edge", calReq, 1);
    calDone = 1; tick(); calDone = 0; lockClass = 2'b10;
    chkState("R7 recovered ready", 6);
    chk(faultCode == 0, "R11 code cleared", faultCode, 0);

    // R6, R10, R11: loss, saturation, timeout
    lockClass = 2'b00; ticks(4);
    chkState("R11 retry after ready", 1);
    lockClass = 2'b10; ticks(4);
    calDone = 1; calSaturated = 1; tick(); calDone = 0; calSaturated = 0;
    chkState("R6 saturation fails", 7);
    chk(faultCode == 5, "R6 sat code", faultCode, 5);
    ticks(3); ticks(4);
    chkState("R6 back at cal", 5);
    calTimeout = 1; tick(); calTimeout = 0;
    chk(faultCode == 5, "R6 timeout code", faultCode, 5);
    ticks(3);
    chkState("R10 fault", 8);
    chk({tecEn, lockerEn, apcEn, biasEn} == 4'd0, "R10 all off",
        {tecEn, lockerEn, apcEn, biasEn}, 0);
    tick();
    chkState("R10 latched", 8);
    faultClear = 1; tick(); faultClear = 0;
    chkState("R10 cleared", 0);
    chk(faultCode == 0, "R10 code cleared", faultCode, 0);

    // R8 stage timeouts
    stageTimeout = 8'd4; tecSettled = 0;
    startReq = 1; tick(); startReq = 0;
    countIn(1, n);
    chk(n == 5, "R8 thermal cycles", n, 5);
    chk(faultCode == 1, "R8 thermal code", faultCode, 1);
    tecSettled = 1; lockClass = 2'b01;
    ticks(3); tick();
    chkState("R8 lock entry", 2);
    countIn(2, n);
    chk(n == 5, "R8 lock cycles", n, 5);
    chk(faultCode == 2, "R8 lock code", faultCode, 2);
    ticks(4);
    countIn(2, n);
    ticks(3);
    chkState("R10 third failure", 8);
    faultClear = 1; tick(); faultClear = 0;

    lockClass = 2'b10; apcSettled = 0;
    startReq = 1; tick(); startReq = 0; ticks(2);
    countIn(3, n);
    chk(n == 5, "R8 power cycles", n, 5);
    chk(faultCode == 3, "R8 power code", faultCode, 3);
    apcSettled = 1; phaseOk = 0; ticks(3); ticks(3);
    countIn(4, n);
    chk(n == 5, "R8 dsp cycles", n, 5);
    chk(faultCode == 4, "R8 dsp code", faultCode, 4);

    summary();
  end

endmodule